// File: doc/BRIEF.md
# Receive Window Guard and No-Response Timers

This block frames the receive window of a contactless reader with two down-counting timers. The guard timer is armed when a transmission ends. While it runs, the receive decoders are held in reset, so the transients that follow the transmitter switching off are not taken as data. The no-response timer is armed when an anticollision slot opens. If no start of frame from a tag arrives before it runs out, it raises a one-cycle interrupt and sets a sticky empty-slot flag.

Each timer has an 8-bit interval register. The two timers count in different units. A guard unit is `GUARD_TICK` clock cycles, which is 128 at a 13.56 MHz carrier clock. A no-response unit is `NORESP_TICK` clock cycles, which is 512 at that clock. Writing the protocol select input loads both interval registers with defaults computed from the protocol code. An override write is therefore only kept if it comes after the protocol write.

Top module: `rx_window_timers`

## Requirements
- R1: After reset, `decoder_reset`, `no_resp_irq` and `no_resp_flag` are 0. The interval registers hold the protocol 0 presets: guard `GUARD_BASE` and no-response `NORESP_BASE`.
- R2: When `tx_end` is sampled high with a guard value G other than 0, `decoder_reset` goes high in the next cycle. It stays high for exactly G*`GUARD_TICK` cycles.
- R3: When `slot_start` is sampled high at edge E with a no-response value N other than 0, and no `rx_sof` follows, `no_resp_irq` is high for exactly one cycle. That cycle follows edge E+N*`NORESP_TICK`.
- R4: `no_resp_flag` goes high in the cycle after `no_resp_irq` and stays high. The next sampled `slot_start` clears it.
- R5: A sampled `rx_sof` stops a running no-response timer without an interrupt. A `slot_start` in the same cycle takes priority and restarts the timer.
- R6: A `tx_end` or `slot_start` that arrives while its timer runs restarts that timer from the full register value.
- R7: A register value of 0 disables that timer. A `tx_end` then leaves `decoder_reset` low, and a `slot_start` produces no interrupt.
- R8: A `proto_we` write of code p loads guard = `GUARD_BASE`+p*`GUARD_STEP` and no-response = `NORESP_BASE`+p*`NORESP_STEP`.
- R9: `guard_we` and `noresp_we` overwrite their registers, and the value is kept until the next protocol write. A protocol write in the same cycle as an override wins.
- R10: A timer start uses the register value held before any write in that same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| proto_we | input | 1 | Protocol select write strobe |
| proto_sel | input | PW | Protocol code |
| guard_we | input | 1 | Guard interval override strobe |
| guard_val | input | W | Guard interval override value |
| noresp_we | input | 1 | No-response interval override strobe |
| noresp_val | input | W | No-response interval override value |
| tx_end | input | 1 | End-of-transmission pulse |
| slot_start | input | 1 | Anticollision slot start pulse |
| rx_sof | input | 1 | Tag start-of-frame detected |
| decoder_reset | output | 1 | Holds receive decoders in reset |
| no_resp_irq | output | 1 | Empty-slot interrupt pulse |
| no_resp_flag | output | 1 | Sticky empty-slot status |

## Verification
The bench sets `GUARD_TICK` to 4 and `NORESP_TICK` to 8. It keeps the default preset bases and steps. With these values, full guard and no-response windows for several interval values fit in a few hundred cycles each. The exact release cycle and interrupt cycle can then be counted edge by edge. The same settings also reach the retrigger case, the stop on start of frame, the priority between a protocol write and an override in the same cycle, and the zero-disable case.

// File: rtl/rxw_pkg.sv
package rxw_pkg;
  // Preset interval for a protocol code: base plus code times step
  function automatic int preset_val(int base, int step, int code);
    return base + step * code;
  endfunction
endpackage

// File: rtl/rxw_interval_timer.sv
module rxw_interval_timer #(
  parameter int W    = 8,
  parameter int TICK = 128
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         start,
  input  logic         stop,
  input  logic [W-1:0] load_val,
  output logic         running,
  output logic         expire
);
  localparam int PRE_W = (TICK > 1) ? $clog2(TICK) : 1;
  localparam logic [PRE_W-1:0] PRE_TOP = PRE_W'(TICK - 1);

  logic [PRE_W-1:0] pre_q;
  logic [W-1:0]     unit_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      running <= 1'b0;
      expire  <= 1'b0;
      pre_q   <= '0;
      unit_q  <= '0;
    end else begin
      expire <= 1'b0;
      if (start) begin
        if (load_val != '0) begin
          running <= 1'b1;
          pre_q   <= PRE_TOP;
          unit_q  <= load_val - 1'b1;
        end else begin
          running <= 1'b0;
        end
      end else if (stop) begin
        running <= 1'b0;
      end else if (running) begin
        if (pre_q == '0) begin
          if (unit_q == '0) begin
            running <= 1'b0;
            expire  <= 1'b1;
          end else begin
            unit_q <= unit_q - 1'b1;
            pre_q  <= PRE_TOP;
          end
        end else begin
          pre_q <= pre_q - 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/rxw_cfg_regs.sv
module rxw_cfg_regs #(
  parameter int W           = 8,
  parameter int PW          = 3,
  parameter int GUARD_BASE  = 3,
  parameter int GUARD_STEP  = 2,
  parameter int NORESP_BASE = 6,
  parameter int NORESP_STEP = 5
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          proto_we,
  input  logic [PW-1:0] proto_sel,
  input  logic          guard_we,
  input  logic [W-1:0]  guard_val,
  input  logic          noresp_we,
  input  logic [W-1:0]  noresp_val,
  output logic [W-1:0]  guard_cfg,
  output logic [W-1:0]  noresp_cfg
);
  import rxw_pkg::*;

  logic [W-1:0] guard_preset, noresp_preset;

  always_comb begin
    guard_preset  = W'(preset_val(GUARD_BASE, GUARD_STEP, int'(proto_sel)));
    noresp_preset = W'(preset_val(NORESP_BASE, NORESP_STEP, int'(proto_sel)));
  end

  // A protocol write outranks any override in the same cycle
  always_ff @(posedge clk) begin
    if (rst) begin
      guard_cfg  <= W'(preset_val(GUARD_BASE, GUARD_STEP, 0));
      noresp_cfg <= W'(preset_val(NORESP_BASE, NORESP_STEP, 0));
    end else if (proto_we) begin
      guard_cfg  <= guard_preset;
      noresp_cfg <= noresp_preset;
    end else begin
      if (guard_we)  guard_cfg  <= guard_val;
      if (noresp_we) noresp_cfg <= noresp_val;
    end
  end
endmodule

// File: rtl/rx_window_timers.sv
module rx_window_timers #(
  parameter int W           = 8,
  parameter int PW          = 3,
  parameter int GUARD_TICK  = 128,
  parameter int NORESP_TICK = 512,
  parameter int GUARD_BASE  = 3,
  parameter int GUARD_STEP  = 2,
  parameter int NORESP_BASE = 6,
  parameter int NORESP_STEP = 5
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          proto_we,
  input  logic [PW-1:0] proto_sel,
  input  logic          guard_we,
  input  logic [W-1:0]  guard_val,
  input  logic          noresp_we,
  input  logic [W-1:0]  noresp_val,
  input  logic          tx_end,
  input  logic          slot_start,
  input  logic          rx_sof,
  output logic          decoder_reset,
  output logic          no_resp_irq,
  output logic          no_resp_flag
);
  logic [W-1:0] guard_cfg, noresp_cfg;
  logic         nr_running;

  rxw_cfg_regs #(
    .W(W), .PW(PW),
    .GUARD_BASE(GUARD_BASE), .GUARD_STEP(GUARD_STEP),
    .NORESP_BASE(NORESP_BASE), .NORESP_STEP(NORESP_STEP)
  ) u_regs (
    .clk(clk), .rst(rst),
    .proto_we(proto_we), .proto_sel(proto_sel),
    .guard_we(guard_we), .guard_val(guard_val),
    .noresp_we(noresp_we), .noresp_val(noresp_val),
    .guard_cfg(guard_cfg), .noresp_cfg(noresp_cfg)
  );

  // Guard timer: its running state is the decoder hold
  logic guard_expire_unused;
  rxw_interval_timer #(.W(W), .TICK(GUARD_TICK)) u_guard (
    .clk(clk), .rst(rst),
    .start(tx_end), .stop(1'b0), .load_val(guard_cfg),
    .running(decoder_reset), .expire(guard_expire_unused)
  );

  rxw_interval_timer #(.W(W), .TICK(NORESP_TICK)) u_noresp (
    .clk(clk), .rst(rst),
    .start(slot_start), .stop(rx_sof), .load_val(noresp_cfg),
    .running(nr_running), .expire(no_resp_irq)
  );

  always_ff @(posedge clk) begin
    if (rst)             no_resp_flag <= 1'b0;
    else if (slot_start) no_resp_flag <= 1'b0;
    else if (no_resp_irq) no_resp_flag <= 1'b1;
  end
endmodule

// File: rtl/rxw_timers_chk.sv
module rxw_timers_chk #(
  parameter int W           = 8,
  parameter int PW          = 3,
  parameter int GUARD_BASE  = 3,
  parameter int GUARD_STEP  = 2,
  parameter int NORESP_BASE = 6,
  parameter int NORESP_STEP = 5
) (
  input logic          clk,
  input logic          rst,
  input logic          proto_we,
  input logic [PW-1:0] proto_sel,
  input logic          tx_end,
  input logic          slot_start,
  input logic          rx_sof,
  input logic [W-1:0]  guard_cfg,
  input logic [W-1:0]  noresp_cfg,
  input logic          decoder_reset,
  input logic          no_resp_irq,
  input logic          no_resp_flag
);
  // R2
  guard_arm_chk: assert property (@(posedge clk) disable iff (rst)
    tx_end && guard_cfg != '0 |=> decoder_reset);
  // R7
  guard_zero_chk: assert property (@(posedge clk) disable iff (rst)
    tx_end && guard_cfg == '0 |=> !decoder_reset);
  // R5
  sof_stop_chk: assert property (@(posedge clk) disable iff (rst)
    rx_sof && !slot_start |=> !no_resp_irq);
  // R3
  irq_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    no_resp_irq |=> !no_resp_irq);
  // R4
  flag_set_chk: assert property (@(posedge clk) disable iff (rst)
    no_resp_irq && !slot_start |=> no_resp_flag);
  // R4
  flag_clear_chk: assert property (@(posedge clk) disable iff (rst)
    slot_start |=> !no_resp_flag);
  // R8
  proto_guard_chk: assert property (@(posedge clk) disable iff (rst)
    proto_we |=> guard_cfg == W'(rxw_pkg::preset_val(GUARD_BASE, GUARD_STEP, int'($past(proto_sel)))));
  // R8
  proto_noresp_chk: assert property (@(posedge clk) disable iff (rst)
    proto_we |=> noresp_cfg == W'(rxw_pkg::preset_val(NORESP_BASE, NORESP_STEP, int'($past(proto_sel)))));
endmodule

bind rx_window_timers rxw_timers_chk #(
  .W(W), .PW(PW),
  .GUARD_BASE(GUARD_BASE), .GUARD_STEP(GUARD_STEP),
  .NORESP_BASE(NORESP_BASE), .NORESP_STEP(NORESP_STEP)
) u_chk (
  .clk(clk), .rst(rst), .proto_we(proto_we), .proto_sel(proto_sel),
  .tx_end(tx_end), .slot_start(slot_start), .rx_sof(rx_sof),
  .guard_cfg(guard_cfg), .noresp_cfg(noresp_cfg),
  .decoder_reset(decoder_reset), .no_resp_irq(no_resp_irq),
  .no_resp_flag(no_resp_flag)
);

// File: tb/rx_window_timers_bench.sv
`timescale 1ns/1ps
module rx_window_timers_bench;
  localparam int GT = 4;
  localparam int NT = 8;
  localparam int GB = 3, GS = 2, NB = 6, NS = 5;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       proto_we = 1'b0;
  logic [2:0] proto_sel = '0;
  logic       guard_we = 1'b0;
  logic [7:0] guard_val = '0;
  logic       noresp_we = 1'b0;
  logic [7:0] noresp_val = '0;
  logic       tx_end = 1'b0, slot_start = 1'b0, rx_sof = 1'b0;
  logic       decoder_reset, no_resp_irq, no_resp_flag;

  int checks = 0, fails = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  rx_window_timers #(.GUARD_TICK(GT), .NORESP_TICK(NT)) u_rx_window_timers (
    .clk(clk), .rst(rst), .proto_we(proto_we), .proto_sel(proto_sel),
    .guard_we(guard_we), .guard_val(guard_val),
    .noresp_we(noresp_we), .noresp_val(noresp_val),
    .tx_end(tx_end), .slot_start(slot_start), .rx_sof(rx_sof),
    .decoder_reset(decoder_reset), .no_resp_irq(no_resp_irq),
    .no_resp_flag(no_resp_flag)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // Write helpers: drive on a falling edge, release on the next one
  task automatic wr_proto(input int p);
    proto_we = 1'b1; proto_sel = 3'(p);
    @(negedge clk); proto_we = 1'b0;
  endtask
  task automatic wr_guard(input int v);
    guard_we = 1'b1; guard_val = 8'(v);
    @(negedge clk); guard_we = 1'b0;
  endtask
  task automatic wr_noresp(input int v);
    noresp_we = 1'b1; noresp_val = 8'(v);
    @(negedge clk); noresp_we = 1'b0;
  endtask
  task automatic pulse_tx();
    tx_end = 1'b1; @(negedge clk); tx_end = 1'b0;
  endtask
  task automatic pulse_slot();
    slot_start = 1'b1; @(negedge clk); slot_start = 1'b0;
  endtask

  // Count consecutive cycles of decoder hold, starting now
  task automatic hold_len(output int n);
    n = 0;
    while (decoder_reset && n < 5000) begin n++; @(negedge clk); end
  endtask
  // Count cycles until the interrupt, up to lim
  task automatic irq_wait(input int lim, output int n);
    n = 0;
    while (!no_resp_irq && n < lim) begin n++; @(negedge clk); end
  endtask

  task automatic t_reset();
    check("R1 decoder_reset", int'(decoder_reset), 0);
    check("R1 no_resp_irq", int'(no_resp_irq), 0);
    check("R1 no_resp_flag", int'(no_resp_flag), 0);
  endtask

  task automatic t_defaults();
    int n;
    pulse_tx(); hold_len(n);
    check("R1 R2 guard preset window", n, GB * GT);
    pulse_slot(); irq_wait(5000, n);
    check("R1 R3 noresp preset delay", n, NB * NT);
    @(negedge clk);
    check("R3 irq one cycle", int'(no_resp_irq), 0);
    check("R4 flag set", int'(no_resp_flag), 1);
    repeat (5) @(negedge clk);
    check("R4 flag held", int'(no_resp_flag), 1);
  endtask

  task automatic t_override();
    int n;
    wr_guard(5); pulse_tx(); hold_len(n);
    check("R9 guard override", n, 5 * GT);
    pulse_tx(); hold_len(n);
    check("R9 guard override persists", n, 5 * GT);
  endtask

  task automatic t_proto();
    int n;
    wr_proto(2);
    pulse_tx(); hold_len(n);
    check("R8 guard preset proto 2", n, (GB + 2 * GS) * GT);
    pulse_slot();
    check("R4 flag cleared by slot", int'(no_resp_flag), 0);
    irq_wait(5000, n);
    check("R8 noresp preset proto 2", n, (NB + 2 * NS) * NT);
    @(negedge clk);
    wr_noresp(2); pulse_slot(); irq_wait(5000, n);
    check("R9 noresp override after proto", n, 2 * NT);
    @(negedge clk);
  endtask

  task automatic t_same_cycle();
    int n;
    proto_we = 1'b1; proto_sel = 3'd1; guard_we = 1'b1; guard_val = 8'd1;
    @(negedge clk); proto_we = 1'b0; guard_we = 1'b0;
    pulse_tx(); hold_len(n);
    check("R9 proto wins same cycle", n, (GB + GS) * GT);
    // Start in the same cycle as an override uses the old value
    tx_end = 1'b1; guard_we = 1'b1; guard_val = 8'd9;
    @(negedge clk); tx_end = 1'b0; guard_we = 1'b0;
    hold_len(n);
    check("R10 start uses old value", n, (GB + GS) * GT);
    pulse_tx(); hold_len(n);
    check("R10 new value next start", n, 9 * GT);
  endtask

  task automatic t_retrigger();
    int n;
    pulse_tx(); repeat (10) @(negedge clk);
    pulse_tx(); hold_len(n);
    check("R6 guard restart", n, 9 * GT);
    wr_noresp(2);
    pulse_slot(); repeat (10) @(negedge clk);
    check("R6 no irq before restart", int'(no_resp_irq), 0);
    pulse_slot(); irq_wait(5000, n);
    check("R6 noresp restart", n, 2 * NT);
    @(negedge clk);
  endtask

  task automatic t_sof();
    int n;
    pulse_slot(); repeat (5) @(negedge clk);
    rx_sof = 1'b1; @(negedge clk); rx_sof = 1'b0;
    irq_wait(60, n);
    check("R5 sof suppresses irq", n, 60);
    check("R5 flag stays low", int'(no_resp_flag), 0);
    slot_start = 1'b1; rx_sof = 1'b1;
    @(negedge clk); slot_start = 1'b0; rx_sof = 1'b0;
    irq_wait(5000, n);
    check("R5 slot wins over sof", n, 2 * NT);
    @(negedge clk);
  endtask

  task automatic t_zero();
    int n;
    wr_guard(0); pulse_tx();
    n = 0;
    repeat (20) begin if (decoder_reset) n++; @(negedge clk); end
    check("R7 zero guard no hold", n, 0);
    wr_noresp(0); pulse_slot(); irq_wait(200, n);
    check("R7 zero noresp no irq", n, 200);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_defaults();
    t_override();
    t_proto();
    t_same_cycle();
    t_retrigger();
    t_sof();
    t_zero();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      done = 1'b1;
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule